// File: doc/BRIEF.md
# Flash Power-Up Write Guard

This block sits in a serial flash device model between the command decoder and the paths that write the array or the status register. It watches two supply-monitor flags that are already synchronized to the clock. The first says the supply is above the write-inhibit threshold. The second says the supply is above the minimum operating level. While the supply is below the inhibit threshold, the block holds the device logic in reset. Once the supply is above that threshold, it grants or refuses each decoded command.

Two independent cycle timers shape the power-up window:

- **Write holdoff timer.** It starts when the inhibit flag rises. Until it expires, every write-class opcode is dropped, and each dropped command gives a one-cycle blocked pulse.
- **Select holdoff timer.** It starts when the minimum-level flag rises. Until it expires, the device cannot be selected, so every command is discarded.

A read can therefore be accepted before the write holdoff ends. If either supply flag falls, both timers restart from zero. Both timers saturate at their terminal counts.

Top module: `pwrup_write_guard`

## Requirements
- R1: In the cycle after the inhibit flag is sampled low, `core_rst_n_o` is 0 and no command is accepted. It is 1 in the cycle after the flag is sampled high.
- R2: The write-class opcodes are 06h, 02h, D8h, C7h and 01h. Such a command is not accepted until WR_DELAY_CYC rising clock edges have sampled the inhibit flag high, with no clear in between. After that, it is accepted.
- R3: Every other opcode is treated as a read. It is accepted once the select delay has elapsed, even while the write holdoff is still running.
- R4: The write timer counts edges that sample the inhibit flag high. The select timer counts edges that sample both flags high. Each timer finishes at its own parameter value: WR_DELAY_CYC for the write timer, SEL_DELAY_CYC for the select timer.
- R5: A command presented before the select delay completes, or while the minimum-level flag is low, is discarded. Neither `cmd_accept_o` nor `wr_blocked_o` rises for it.
- R6: A falling minimum-level flag, or a low inhibit flag, returns both timers to zero.
- R7: A timer that has reached its terminal count stays there for as long as its supply condition holds.
- R8: A write-class command dropped during the write holdoff raises `wr_blocked_o` for exactly one cycle and leaves `cmd_accept_o` low.
- R9: While `cs_n_i` is high, a command strobe is ignored: both `cmd_accept_o` and `wr_blocked_o` stay 0.
- R10: Asserting `rst_n` drives all outputs to 0 at once and clears both timers. The internal logic leaves reset on the second rising edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_inh_ok_i | input | 1 | Supply above write-inhibit threshold (synchronized) |
| sup_min_ok_i | input | 1 | Supply above minimum operating level (synchronized) |
| cs_n_i | input | 1 | Chip select, active low |
| cmd_valid_i | input | 1 | Decoded-command strobe |
| cmd_op_i | input | 8 | Decoded opcode |
| core_rst_n_o | output | 1 | Global device logic reset, active low |
| cmd_accept_o | output | 1 | Command granted, one cycle after the strobe |
| wr_blocked_o | output | 1 | Write-class command dropped, one-cycle pulse |

## Verification
All three outputs are registered. Each is therefore due in the cycle after the rising edge that samples its stimulus. The bench changes inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge.

Expected timer expiry is counted in sampling edges from the flag change, so a write is blocked one edge before WR_DELAY_CYC and granted at exactly that count. After a reset release, the bench allows the two synchronizer edges before it expects the logic to respond.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef logic [7:0] opcode_t;

  localparam opcode_t OP_WR_EN   = 8'h06;
  localparam opcode_t OP_PG_PROG = 8'h02;
  localparam opcode_t OP_SEC_ER  = 8'hD8;
  localparam opcode_t OP_ALL_ER  = 8'hC7;
  localparam opcode_t OP_WR_STAT = 8'h01;

  function automatic logic op_is_write(input opcode_t op);
    return (op == OP_WR_EN) || (op == OP_PG_PROG) || (op == OP_SEC_ER) ||
           (op == OP_ALL_ER) || (op == OP_WR_STAT);
  endfunction
endpackage

// File: rtl/pwg_delay_timer.sv
module pwg_delay_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_lim;

  assign at_lim = (cnt_q == LIM_C);
  assign done_o = at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (run_i && !at_lim) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lim && !clr_i) |=> (cnt_q == LIM_C));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !at_lim) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/pwg_cmd_gate.sv
module pwg_cmd_gate
  import pwg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    live_i,
  input  logic    sel_rdy_i,
  input  logic    wr_rdy_i,
  input  logic    cs_n_i,
  input  logic    cmd_valid_i,
  input  opcode_t cmd_op_i,
  output logic    accept_o,
  output logic    blocked_o
);
  logic is_wr, cmd_go;
  logic accept_d, accept_q, blocked_d, blocked_q;

  assign is_wr = op_is_write(cmd_op_i);
  assign cmd_go = cmd_valid_i && !cs_n_i && live_i && sel_rdy_i;

  always_comb begin
    accept_d  = cmd_go && (!is_wr || wr_rdy_i);
    blocked_d = cmd_go && is_wr && !wr_rdy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q  <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      accept_q  <= accept_d;
      blocked_q <= blocked_d;
    end
  end

  assign accept_o  = accept_q;
  assign blocked_o = blocked_q;

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && is_wr && !wr_rdy_i) |=> !accept_q);

  // R5
  unsel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !sel_rdy_i) |=> (!accept_q && !blocked_q));

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (!accept_q && !blocked_q));

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_q && blocked_q));
endmodule

// File: rtl/pwrup_write_guard.sv
module pwrup_write_guard
  import pwg_pkg::*;
#(
  parameter int unsigned WR_DELAY_CYC  = 10000,
  parameter int unsigned SEL_DELAY_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_inh_ok_i,
  input  logic       sup_min_ok_i,
  input  logic       cs_n_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_op_i,
  output logic       core_rst_n_o,
  output logic       cmd_accept_o,
  output logic       wr_blocked_o
);
  logic rst_s1_q, rst_s2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  logic min_q, core_q;
  logic min_fell, both_ok;
  logic wr_clr, sel_clr, wr_rdy, sel_rdy;

  assign min_fell = min_q && !sup_min_ok_i;
  assign both_ok  = sup_inh_ok_i && sup_min_ok_i;
  assign wr_clr   = !sup_inh_ok_i || min_fell;
  assign sel_clr  = !both_ok;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      min_q  <= 1'b0;
      core_q <= 1'b0;
    end else begin
      min_q  <= sup_min_ok_i;
      core_q <= sup_inh_ok_i;
    end
  end
  assign core_rst_n_o = core_q;

  pwg_delay_timer #(.LIMIT(WR_DELAY_CYC)) i_wr_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (sup_inh_ok_i),
    .clr_i  (wr_clr),
    .done_o (wr_rdy)
  );

  pwg_delay_timer #(.LIMIT(SEL_DELAY_CYC)) i_sel_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (both_ok),
    .clr_i  (sel_clr),
    .done_o (sel_rdy)
  );

  pwg_cmd_gate i_gate (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .live_i      (both_ok),
    .sel_rdy_i   (sel_rdy),
    .wr_rdy_i    (wr_rdy),
    .cs_n_i      (cs_n_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .accept_o    (cmd_accept_o),
    .blocked_o   (wr_blocked_o)
  );

  // R1
  inhibit_rst_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sup_inh_ok_i |=> (!core_rst_n_o && !cmd_accept_o));

  // R6
  min_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    min_fell |=> !wr_rdy);
endmodule

// File: tb/test_pwrup_write_guard.sv
`timescale 1ns/1ps
module test_pwrup_write_guard;
  localparam int WR_D  = 6;
  localparam int SEL_D = 2;
  localparam int NV    = 20;

  logic clk = 1'b0;
  logic rst_n, inh, mn, cs_n, vld;
  logic [7:0] op;
  logic core_rst_n, acc, blk;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwrup_write_guard #(.WR_DELAY_CYC(WR_D), .SEL_DELAY_CYC(SEL_D)) i_pwrup_write_guard (
    .clk(clk), .rst_n(rst_n), .sup_inh_ok_i(inh), .sup_min_ok_i(mn),
    .cs_n_i(cs_n), .cmd_valid_i(vld), .cmd_op_i(op),
    .core_rst_n_o(core_rst_n), .cmd_accept_o(acc), .wr_blocked_o(blk)
  );

  // {req[3:0], inh, min, cs_n, valid, op[7:0], exp_rst_n, exp_acc, exp_blk}
  localparam logic [18:0] VEC [NV] = '{
    {4'd1, 4'b0010, 8'h00, 3'b000},  // R1 inhibited, idle
    {4'd1, 4'b0001, 8'h03, 3'b000},  // R1 read while inhibited
    {4'd1, 4'b1010, 8'h00, 3'b100},  // R1 leave inhibit
    {4'd5, 4'b1001, 8'h03, 3'b100},  // R5 min level low
    {4'd4, 4'b1110, 8'h00, 3'b100},  // R4 select timer starts
    {4'd5, 4'b1101, 8'h03, 3'b100},  // R5 select delay not done
    {4'd3, 4'b1101, 8'h03, 3'b110},  // R3 read during write holdoff
    {4'd2, 4'b1101, 8'h06, 3'b101},  // R2 write enable blocked
    {4'd2, 4'b1101, 8'h06, 3'b110},  // R2 write enable granted
    {4'd3, 4'b1101, 8'h05, 3'b110},  // R3 status read
    {4'd9, 4'b1111, 8'h02, 3'b100},  // R9 chip select idle
    {4'd2, 4'b1101, 8'hD8, 3'b110},  // R2 sector erase
    {4'd2, 4'b1101, 8'hC7, 3'b110},  // R2 bulk erase
    {4'd2, 4'b1101, 8'h01, 3'b110},  // R2 write status
    {4'd6, 4'b1001, 8'h03, 3'b100},  // R6 min level drops
    {4'd6, 4'b1110, 8'h00, 3'b100},  // R6 recount
    {4'd6, 4'b1110, 8'h00, 3'b100},  // R6 recount
    {4'd6, 4'b1101, 8'h02, 3'b101},  // R6 write timer restarted
    {4'd8, 4'b1110, 8'h00, 3'b100},  // R8 pulse ended
    {4'd1, 4'b0101, 8'h03, 3'b000}   // R1 re-inhibit
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic i, input logic m, input logic c, input logic v, input logic [7:0] o);
    inh = i; mn = m; cs_n = c; vld = v; op = o;
    @(posedge clk); #1;
  endtask

  task automatic chk3(input string tag, input logic r, input logic a, input logic b);
    chk({tag, " core_rst_n"}, core_rst_n, r);
    chk({tag, " accept"}, acc, a);
    chk({tag, " blocked"}, blk, b);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; inh = 0; mn = 0; cs_n = 1; vld = 0; op = 8'h00;
    #23;
    chk3("R10 reset state", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      cyc(v[14], v[13], v[12], v[11], v[10:3]);
      chk($sformatf("R%0d vec%0d rst_n", v[18:15], i), core_rst_n, v[2]);
      chk($sformatf("R%0d vec%0d accept", v[18:15], i), acc, v[1]);
      chk($sformatf("R%0d vec%0d blocked", v[18:15], i), blk, v[0]);
    end

    // R4: write timer expires exactly WR_D edges after inhibit rises
    for (int k = 0; k < WR_D - 1; k++) cyc(1, 1, 1, 0, 8'h00);
    cyc(1, 1, 0, 1, 8'h06);
    chk3("R4 one edge short", 1'b1, 1'b0, 1'b1);
    cyc(1, 1, 0, 1, 8'h06);
    chk3("R4 at terminal count", 1'b1, 1'b1, 1'b0);

    // R7: saturation, no wrap after a long hold
    for (int k = 0; k < 40; k++) cyc(1, 1, 1, 0, 8'h00);
    cyc(1, 1, 0, 1, 8'h02);
    chk3("R7 saturated", 1'b1, 1'b1, 1'b0);

    // R10: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1 chk3("R10 async clear", 1'b0, 1'b0, 1'b0);
    @(posedge clk); #3 rst_n = 1'b1;
    @(posedge clk); #1;
    cyc(1, 1, 1, 0, 8'h00);
    cyc(1, 1, 0, 1, 8'h06);
    chk3("R10 timers cleared", 1'b1, 1'b0, 1'b0);
    cyc(1, 1, 1, 0, 8'h00);
    cyc(1, 1, 0, 1, 8'hC7);
    chk3("R10 write held after reset", 1'b1, 1'b0, 1'b1);
    cyc(1, 1, 1, 0, 8'h00);
    chk3("R8 single pulse", 1'b1, 1'b0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule